// File: doc/BRIEF.md
# Linked-Channel PWM Generator

This block produces one pulse-width-modulated output from two cooperating 16-bit down-counters. The first counter, the pacing channel, runs as a free-running interval timer. It reloads itself from a period value and so fixes the repetition rate. Each time it reloads, it restarts the second counter, the width channel. The width channel is a one-shot timer: it drives the output active when it starts and inactive when it runs out. It then parks at all-ones and waits for the next restart.

Counting advances only on clock cycles where a one-cycle count strobe is high; a prescaler outside the block supplies that strobe. Period and width values can be written at any time. In the paired-update mode, both new values are held back together. They are applied at the next point where the pacing channel starts a new count, so no output cycle ever mixes an old period with a new width.

Top module: `pwm_sync_pair`

## Requirements
- R1: While reset is held and after it is released, `running`, `pace_irq` and `width_irq` are 0, and `pwm_out` equals `out_invert`, which is the inactive level.
- R2: A `start_pulse` puts `running` at 1 and loads both counters. In the following cycle, `pace_irq` is 1, and the output is active if the width value is non-zero. This happens without any count strobe. When `stop_pulse` is high in the same cycle, stop wins.
- R3: While running, `pace_irq` pulses once every period+1 count strobes, and the pacing counter reloads at each pulse.
- R4: Each pacing reload makes the output active. The output stays active for exactly width count strobes, then goes inactive, and `width_irq` pulses in the cycle after the edge where it went inactive.
- R5: A width of 0 keeps the output inactive for the whole period. A width greater than period+1 keeps it active continuously, and `width_irq` never pulses.
- R6: Cycles with `cnt_en` at 0 change neither counter. Without a start pulse, no interrupt is raised in such a cycle.
- R7: A `stop_pulse` clears `running` and freezes the counters and the output level. No interrupt is raised while stopped. A later start reloads both counters from their values.
- R8: With `resync_en` at 1, writes are held in staging registers. A duty write arms the update. At the next pacing reload or start, the staged period and width are applied together. A period write alone changes nothing.
- R9: With `resync_en` at 0, a write takes effect at the next reload of its counter, without waiting for the other value.
- R10: With `out_invert` at 1, `pwm_out` is the complement of the active level.
- R11: Each interrupt is a one-cycle pulse for each event. Back-to-back pulses occur only when the events themselves fall in consecutive cycles.
- R12: When the width channel expires on the same strobe as a pacing reload (width = period+1), the restart wins. The output stays active, and `width_irq` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | One-cycle count strobe from the prescaler |
| start_pulse | input | 1 | Start trigger for both channels |
| stop_pulse | input | 1 | Stop trigger for both channels |
| period_wr | input | 1 | Write strobe for the period value |
| period_din | input | 16 | Period value (pacing counter reload) |
| duty_wr | input | 1 | Write strobe for the width value; arms a paired update |
| duty_din | input | 16 | Width value (width counter reload) |
| resync_en | input | 1 | 1 = paired update at the pacing start, 0 = direct write |
| out_invert | input | 1 | Output polarity, 1 = inverted |
| pwm_out | output | 1 | PWM output |
| pace_irq | output | 1 | Pacing channel interrupt pulse |
| width_irq | output | 1 | Width channel interrupt pulse |
| running | output | 1 | Channels enabled status |

## Verification
The pacing reload and the width channel's expiry can fall on the same count strobe. This happens whenever the width value is exactly one more than the period value. The bench provokes this with table rows where width = period+1, including the degenerate period 0, width 1 case where the clash happens on every strobe. Each such row is judged over a window of two periods: the output must be active on every sampled cycle, and exactly two width interrupts must still be counted.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int CNT_W      = 16;
  localparam int NUM_FIELDS = 2;
  localparam int IDX_PERIOD = 0;
  localparam int IDX_DUTY   = 1;
endpackage

// File: rtl/pwm_reload_bank.sv
module pwm_reload_bank
  import pwm_sync_pkg::*;
#(
  parameter int W   = CNT_W,
  parameter int NF  = NUM_FIELDS,
  parameter int ARM = IDX_DUTY
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NF-1:0]         wr,
  input  logic [NF-1:0][W-1:0]  din,
  input  logic                  sync_en,
  input  logic                  take,
  output logic [NF-1:0][W-1:0]  eff
);
  logic [NF-1:0][W-1:0] stage_q, stage_d;
  logic [NF-1:0][W-1:0] live_q, live_d;
  logic                 pend_q, pend_d;
  logic                 apply;

  assign apply  = take & pend_q;
  assign pend_d = (pend_q & ~take) | (wr[ARM] & sync_en);

  generate
    for (genvar f = 0; f < NF; f++) begin : g_field
      assign eff[f] = pend_q ? stage_q[f] : live_q[f];

      always_comb begin
        stage_d[f] = stage_q[f];
        live_d[f]  = live_q[f];
        if (wr[f]) stage_d[f] = din[f];
        if (apply) live_d[f] = stage_q[f];
        if (wr[f] && !sync_en) live_d[f] = din[f];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[f] <= '0;
          live_q[f]  <= '0;
        end else begin
          stage_q[f] <= stage_d[f];
          live_q[f]  <= live_d[f];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/pwm_pace_chan.sv
module pwm_pace_chan
  import pwm_sync_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,
  input  logic         stop,
  input  logic [W-1:0] load_val,
  output logic         run,
  output logic         load_evt,
  output logic         irq
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_d;
  logic         expire;
  logic         step;

  assign expire   = run & tick & (cnt_q == '0);
  assign load_evt = ~stop & (start | expire);
  assign step     = run & ~stop & tick;

  always_comb begin
    run_d = run;
    cnt_d = cnt_q;
    if (stop)       run_d = 1'b0;
    else if (start) run_d = 1'b1;
    if (load_evt)   cnt_d = load_val;
    else if (step)  cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      run   <= run_d;
      cnt_q <= cnt_d;
      irq   <= load_evt;
    end
  end
endmodule

// File: rtl/pwm_width_chan.sv
module pwm_width_chan
  import pwm_sync_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         restart,
  input  logic [W-1:0] load_val,
  output logic         active,
  output logic         irq
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         armed_q, armed_d;
  logic         active_d;
  logic         expire;

  assign expire = armed_q & go & (cnt_q <= W'(1));

  always_comb begin
    cnt_d    = cnt_q;
    armed_d  = armed_q;
    active_d = active;
    if (restart) begin
      cnt_d    = load_val;
      armed_d  = 1'b1;
      active_d = (load_val != '0);
    end else if (expire) begin
      cnt_d    = '1;
      armed_d  = 1'b0;
      active_d = 1'b0;
    end else if (armed_q && go) begin
      cnt_d    = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      armed_q <= 1'b0;
      active  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      active  <= active_d;
      irq     <= expire;
    end
  end
endmodule

// File: rtl/pwm_sync_pair.sv
module pwm_sync_pair
  import pwm_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_en,
  input  logic        start_pulse,
  input  logic        stop_pulse,
  input  logic        period_wr,
  input  logic [15:0] period_din,
  input  logic        duty_wr,
  input  logic [15:0] duty_din,
  input  logic        resync_en,
  input  logic        out_invert,
  output logic        pwm_out,
  output logic        pace_irq,
  output logic        width_irq,
  output logic        running
);
  logic [1:0]                       rst_sync_q;
  logic                             rst_core;
  logic [NUM_FIELDS-1:0]            wr_vec;
  logic [NUM_FIELDS-1:0][CNT_W-1:0] din_vec;
  logic [NUM_FIELDS-1:0][CNT_W-1:0] eff_vec;
  logic                             pace_load;
  logic                             width_go;
  logic                             s_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core = rst_sync_q[1];

  assign wr_vec[IDX_PERIOD]  = period_wr;
  assign wr_vec[IDX_DUTY]    = duty_wr;
  assign din_vec[IDX_PERIOD] = period_din;
  assign din_vec[IDX_DUTY]   = duty_din;

  pwm_reload_bank #(.W(CNT_W), .NF(NUM_FIELDS), .ARM(IDX_DUTY)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core),
    .wr      (wr_vec),
    .din     (din_vec),
    .sync_en (resync_en),
    .take    (pace_load),
    .eff     (eff_vec)
  );

  pwm_pace_chan #(.W(CNT_W)) u_pace (
    .clk      (clk),
    .rst_n    (rst_core),
    .tick     (cnt_en),
    .start    (start_pulse),
    .stop     (stop_pulse),
    .load_val (eff_vec[IDX_PERIOD]),
    .run      (running),
    .load_evt (pace_load),
    .irq      (pace_irq)
  );

  assign width_go = running & ~stop_pulse & cnt_en;

  pwm_width_chan #(.W(CNT_W)) u_width (
    .clk      (clk),
    .rst_n    (rst_core),
    .go       (width_go),
    .restart  (pace_load),
    .load_val (eff_vec[IDX_DUTY]),
    .active   (s_active),
    .irq      (width_irq)
  );

  assign pwm_out = s_active ^ out_invert;
endmodule

// File: rtl/pwm_sync_pair_chk.sv
module pwm_sync_pair_chk (
  input logic clk,
  input logic rst_core,
  input logic cnt_en,
  input logic start_pulse,
  input logic stop_pulse,
  input logic out_invert,
  input logic pwm_out,
  input logic pace_irq,
  input logic width_irq,
  input logic running,
  input logic s_active
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_core)
    (start_pulse && !stop_pulse) |=> (pace_irq && running));

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_core)
    stop_pulse |=> !running);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_core)
    (!running && !start_pulse) |=> (!pace_irq && !width_irq));

  assert_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_core)
    (!cnt_en && !start_pulse) |=> (!pace_irq && !width_irq));

  assert_rise_on_pace_R4: assert property (@(posedge clk) disable iff (!rst_core)
    $rose(s_active) |-> pace_irq);

  assert_expiry_inactive_R4: assert property (@(posedge clk) disable iff (!rst_core)
    (width_irq && !pace_irq) |-> (pwm_out == out_invert));
endmodule

bind pwm_sync_pair pwm_sync_pair_chk u_chk (.*);

// File: tb/pwm_sync_pair_test.sv
module pwm_sync_pair_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    int p; int d; bit inv; int act; int m; int s;
  } vec_t;

  // period, width, invert, active cycles / irq counts over 2*(period+1)
  localparam vec_t VECS [8] = '{
    '{9,  4,  1'b0, 8,  2, 2},   // R3 R4 nominal
    '{9,  0,  1'b0, 0,  2, 2},   // R5 zero width
    '{9,  10, 1'b1, 20, 2, 2},   // R12 R10 coincident expiry, inverted
    '{9,  15, 1'b0, 20, 2, 0},   // R5 width beyond period
    '{4,  1,  1'b0, 2,  2, 2},   // R4 short width
    '{0,  0,  1'b1, 0,  2, 2},   // R5 R10 minimal period
    '{0,  1,  1'b0, 2,  2, 2},   // R12 clash every strobe
    '{19, 16, 1'b0, 32, 2, 2}    // R3 R4 longer period
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cnt_en, start_pulse, stop_pulse, period_wr, duty_wr, resync_en, out_invert;
  logic [15:0] period_din, duty_din;
  logic pwm_out, pace_irq, width_irq, running;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_sync_pair uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .period_wr(period_wr), .period_din(period_din),
    .duty_wr(duty_wr), .duty_din(duty_din), .resync_en(resync_en),
    .out_invert(out_invert), .pwm_out(pwm_out), .pace_irq(pace_irq),
    .width_irq(width_irq), .running(running)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnt_en = 1'b0; start_pulse = 1'b0; stop_pulse = 1'b0;
    period_wr = 1'b0; duty_wr = 1'b0; period_din = '0; duty_din = '0;
    resync_en = 1'b0; out_invert = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic wr_period(input int v);
    period_wr = 1'b1; period_din = 16'(v); cyc(); period_wr = 1'b0;
  endtask

  task automatic wr_duty(input int v);
    duty_wr = 1'b1; duty_din = 16'(v); cyc(); duty_wr = 1'b0;
  endtask

  task automatic pulse_start();
    start_pulse = 1'b1; cyc(); start_pulse = 1'b0;
  endtask

  task automatic measure(input int n, output int act, output int m, output int s);
    act = 0; m = 0; s = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (pwm_out ^ out_invert) act++;
      if (pace_irq)  m++;
      if (width_irq) s++;
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    int a, m, s;
    // R1 reset state
    rst_n = 1'b0; cnt_en = 1'b0; start_pulse = 1'b0; stop_pulse = 1'b0;
    period_wr = 1'b0; duty_wr = 1'b0; period_din = '0; duty_din = '0;
    resync_en = 1'b0; out_invert = 1'b0;
    cyc(2);
    chk(pwm_out == 1'b0 && !pace_irq && !width_irq && !running, "R1 in reset",
        {pwm_out, pace_irq, width_irq, running}, 0);
    do_reset();
    chk(pwm_out == 1'b0 && !running, "R1 after release", {pwm_out, running}, 0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      do_reset();
      cnt_en = 1'b1;
      out_invert = VECS[v].inv;
      wr_period(VECS[v].p);
      wr_duty(VECS[v].d);
      pulse_start();
      cyc(5);
      measure(2 * (VECS[v].p + 1), a, m, s);
      chk(a == VECS[v].act, $sformatf("R4 vec%0d active", v), a, VECS[v].act);
      chk(m == VECS[v].m,   $sformatf("R3 vec%0d pace_irq", v), m, VECS[v].m);
      chk(s == VECS[v].s,   $sformatf("R11 vec%0d width_irq", v), s, VECS[v].s);
    end

    // R2 start without strobe, R6 gating
    do_reset();
    wr_period(9); wr_duty(3);
    pulse_start();
    chk(pace_irq && running && pwm_out, "R2 start pulse", {pace_irq, running, pwm_out}, 7);
    cyc();
    chk(!pace_irq, "R11 start irq single", pace_irq, 0);
    measure(20, a, m, s);
    chk(a == 20 && s == 0 && m == 0, "R6 no strobe holds", a, 20);
    cnt_en = 1'b1; cyc(); cnt_en = 1'b0; cyc();
    cnt_en = 1'b1; cyc(); cnt_en = 1'b0; cyc();
    chk(pwm_out == 1'b1, "R6 two strobes still active", pwm_out, 1);
    cnt_en = 1'b1; cyc(); cnt_en = 1'b0;
    chk(pwm_out == 1'b0 && width_irq, "R4 expiry on third strobe", {pwm_out, width_irq}, 1);

    // R7 stop holds, restart reloads
    do_reset();
    cnt_en = 1'b1;
    wr_period(9); wr_duty(5);
    pulse_start();
    cyc(2);
    stop_pulse = 1'b1; cyc(); stop_pulse = 1'b0;
    chk(!running && pwm_out, "R7 stop freezes", {running, pwm_out}, 1);
    measure(30, a, m, s);
    chk(a == 30 && m == 0 && s == 0, "R7 frozen while stopped", a + m + s, 30);
    pulse_start();
    chk(pace_irq && running, "R7 restart", {pace_irq, running}, 3);
    a = pwm_out ? 1 : 0;
    for (int i = 0; i < 9; i++) begin
      cyc();
      if (pwm_out) a++;
    end
    chk(a == 5, "R7 full width after restart", a, 5);

    // R2 start and stop together: stop wins
    start_pulse = 1'b1; stop_pulse = 1'b1; cyc();
    start_pulse = 1'b0; stop_pulse = 1'b0;
    chk(!running && !pace_irq, "R2 stop beats start", {running, pace_irq}, 0);

    // R8 paired update
    do_reset();
    cnt_en = 1'b1; resync_en = 1'b1;
    wr_period(9); wr_duty(4);
    pulse_start();
    cyc(3);
    measure(20, a, m, s);
    chk(a == 8 && m == 2, "R8 staged initial", a, 8);
    wr_period(4);
    cyc(25);
    measure(20, a, m, s);
    chk(a == 8 && m == 2, "R8 period alone held", a * 10 + m, 82);
    wr_duty(1);
    cyc(15);
    measure(20, a, m, s);
    chk(a == 4 && m == 4, "R8 pair applied", a * 10 + m, 44);

    // R9 direct write
    do_reset();
    cnt_en = 1'b1;
    wr_period(9); wr_duty(4);
    pulse_start();
    cyc(2);
    wr_period(4);
    cyc(15);
    measure(20, a, m, s);
    chk(a == 16 && m == 4, "R9 direct period", a * 10 + m, 164);

    done = 1'b1;
    report();
    $finish;
  end
endmodule